// File: doc/BRIEF.md
# Windowed Display Memory Write Addresser

This block turns a stream of pixel data bytes into write cycles for a greyscale display memory of 80 rows by 64 bytes, each byte holding two 4-bit pixels. It holds a current column and row together with a rectangular window made of a start and an end bound on each axis. Every accepted data byte goes out on the memory write port at the current position. The position then steps to the next place inside the window.

Stepping follows one of two orders, picked by a live order-select input. In row-major order the column moves first. In column-major order the row moves first. A window load replaces all four bounds at once and puts the position back at the window origin. A pending-redraw flag tells the scan-out side that the memory has changed. The scan-out side clears the flag with an acknowledge.

Top module: `winAddrTop`

## Requirements
- R1: After reset the current column and row are 0, the column end is 63, the row end is 79, the column and row starts are 0, `redrawPending` is 0 and `memWe` is 0. The first byte written after reset goes to address 0.
- R2: While `byteValid` is high and `winLoad` is low, `memWe` is high in the same cycle, `memAddr` equals column + 64 × row, and `memData` equals `byteIn`.
- R3: In row-major order (`colMajor` = 0), a write at a column below the column end leaves the row unchanged and moves the column up by one.
- R4: In row-major order, a write at a column at or past the column end sends the column back to the column start and moves the row up by one.
- R5: In row-major order, a row that would pass the row end returns to the row start.
- R6: In column-major order (`colMajor` = 1), the row moves up by one until it passes the row end. It then returns to the row start and the column moves up by one. A column that passes the column end returns to the column start.
- R7: A pulse on `winLoad` stores the four bounds and sets the current column and row to the new starts at the same clock edge. A row bound of 80 or more is stored as the value minus 80.
- R8: When `winLoad` and `byteValid` are both high in one cycle, the load wins. `memWe` stays low, `redrawPending` is not set by that byte, and the position becomes the new window start.
- R9: `redrawPending` rises at the clock edge that ends a write cycle. `redrawAck` clears it when no write happens in that cycle. A write together with `redrawAck` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A data byte is offered this cycle |
| byteIn | input | 8 | Data byte (two 4-bit pixels) |
| colMajor | input | 1 | 1 selects column-major stepping |
| winLoad | input | 1 | Load new window bounds |
| colFirst | input | 6 | Column start bound to load |
| colLast | input | 6 | Column end bound to load |
| rowFirst | input | 7 | Row start bound to load |
| rowLast | input | 7 | Row end bound to load |
| redrawAck | input | 1 | Scan-out acknowledges the redraw |
| memWe | output | 1 | Display memory write enable |
| memAddr | output | 13 | Display memory byte address |
| memData | output | 8 | Display memory write data |
| redrawPending | output | 1 | Memory changed since last acknowledge |

## Verification
A bad current position shows up on `memAddr` at the very next accepted byte, because the address is formed directly from the position registers. A bad bound shows up only when the position reaches the edge of the window, so each window is filled past its wrap point and walked back to its origin. A bad wrap or a bad order choice therefore gives a wrong address within one window's worth of bytes. Flag errors show one cycle after the write or the acknowledge that should have moved the flag.

// File: rtl/winAddrPkg.sv
package winAddrPkg;
  localparam int COLS   = 64;
  localparam int ROWS   = 80;
  localparam int COL_W  = $clog2(COLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int ADDR_W = $clog2(COLS * ROWS);
  localparam int DATA_W = 8;

  typedef struct packed {
    logic load;   // take new window, jump to origin
    logic step;   // write accepted, advance position
    logic vert;   // column-major stepping for this step
  } stepCtl_t;
endpackage

// File: rtl/winAddrCtrl.sv
module winAddrCtrl
  import winAddrPkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     byteValid,
  input  logic     winLoad,
  input  logic     colMajor,
  input  logic     redrawAck,
  output stepCtl_t ctl,
  output logic     redrawPending
);
  // a window load always wins over a data byte in the same cycle
  always_comb begin
    ctl.load = winLoad;
    ctl.step = byteValid & ~winLoad;
    ctl.vert = colMajor;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          redrawPending <= 1'b0;
    else if (ctl.step)   redrawPending <= 1'b1;
    else if (redrawAck)  redrawPending <= 1'b0;
  end

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    winLoad |-> !ctl.step);
  p_dirty_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> redrawPending);
  p_dirty_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redrawAck && !ctl.step) |=> !redrawPending);
endmodule

// File: rtl/winAddrPath.sv
module winAddrPath
  import winAddrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  stepCtl_t          ctl,
  input  logic [COL_W-1:0]  colFirst,
  input  logic [COL_W-1:0]  colLast,
  input  logic [ROW_W-1:0]  rowFirst,
  input  logic [ROW_W-1:0]  rowLast,
  output logic [ADDR_W-1:0] curAddr
);
  logic [COL_W-1:0] col, colStart, colEnd, colNext;
  logic [ROW_W-1:0] row, rowStart, rowEnd, rowNext;
  logic [ROW_W-1:0] rowFirstMod, rowLastMod;
  logic [COL_W:0]   colPlus, colTmp;
  logic [ROW_W:0]   rowPlus, rowTmp;
  logic             colAtEnd, rowAtEnd;

  // fold row bounds into the 0..ROWS-1 range
  always_comb begin
    rowFirstMod = (int'(rowFirst) >= ROWS) ? ROW_W'(int'(rowFirst) - ROWS) : rowFirst;
    rowLastMod  = (int'(rowLast)  >= ROWS) ? ROW_W'(int'(rowLast)  - ROWS) : rowLast;
  end

  always_comb begin
    colAtEnd = (col >= colEnd);
    rowAtEnd = (row >= rowEnd);
    colPlus  = {1'b0, col} + 1'b1;
    rowPlus  = {1'b0, row} + 1'b1;
    colTmp   = {1'b0, col};
    rowTmp   = {1'b0, row};
    if (ctl.vert) begin
      rowNext = rowAtEnd ? rowStart : rowPlus[ROW_W-1:0];
      colTmp  = rowAtEnd ? colPlus : {1'b0, col};
      colNext = (colTmp > {1'b0, colEnd}) ? colStart : colTmp[COL_W-1:0];
    end else begin
      colNext = colAtEnd ? colStart : colPlus[COL_W-1:0];
      rowTmp  = colAtEnd ? rowPlus : {1'b0, row};
      rowNext = (rowTmp > {1'b0, rowEnd}) ? rowStart : rowTmp[ROW_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= '0;
      colStart <= '0;
      rowStart <= '0;
      colEnd   <= COL_W'(COLS - 1);
      rowEnd   <= ROW_W'(ROWS - 1);
    end else if (ctl.load) begin
      colStart <= colFirst;
      colEnd   <= colLast;
      rowStart <= rowFirstMod;
      rowEnd   <= rowLastMod;
      col      <= colFirst;
      row      <= rowFirstMod;
    end else if (ctl.step) begin
      col <= colNext;
      row <= rowNext;
    end
  end

  assign curAddr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);

  p_row_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) < ROWS);
  p_load_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (col == colStart && row == rowStart));
  p_hwrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.load && !ctl.vert && colAtEnd) |=> (col == colStart));
  p_vstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.load && ctl.vert && !rowAtEnd) |=> (row == $past(row) + 1'b1 && $stable(col)));
endmodule

// File: rtl/winAddrTop.sv
module winAddrTop
  import winAddrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              colMajor,
  input  logic              winLoad,
  input  logic [COL_W-1:0]  colFirst,
  input  logic [COL_W-1:0]  colLast,
  input  logic [ROW_W-1:0]  rowFirst,
  input  logic [ROW_W-1:0]  rowLast,
  input  logic              redrawAck,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              redrawPending
);
  stepCtl_t ctl;

  winAddrCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .winLoad(winLoad),
    .colMajor(colMajor), .redrawAck(redrawAck), .ctl(ctl),
    .redrawPending(redrawPending)
  );

  winAddrPath u_path (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .colFirst(colFirst),
    .colLast(colLast), .rowFirst(rowFirst), .rowLast(rowLast),
    .curAddr(memAddr)
  );

  assign memWe   = ctl.step;
  assign memData = byteIn;

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (int'(memAddr) < COLS * ROWS));
endmodule

// File: tb/sim_winAddrTop.sv
`timescale 1ns/1ps
module sim_winAddrTop;
  logic clk = 0, rst_n = 0;
  logic byteValid = 0, colMajor = 0, winLoad = 0, redrawAck = 0;
  logic [7:0] byteIn = 0;
  logic [5:0] colFirst = 0, colLast = 0;
  logic [6:0] rowFirst = 0, rowLast = 0;
  logic memWe, redrawPending;
  logic [12:0] memAddr;
  logic [7:0] memData;

  int nVec = 0, nBad = 0;
  logic [20:0] expQ[$];
  int mCol, mRow, mCs, mCe, mRs, mRe;

  always #2 clk = ~clk;

  winAddrTop u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mCol = 0; mRow = 0; mCs = 0; mRs = 0; mCe = 63; mRe = 79;
  endtask

  task automatic modelStep(input bit v);
    int t;
    if (v) begin
      if (mRow >= mRe) begin mRow = mRs; t = mCol + 1; end else begin mRow++; t = mCol; end
      mCol = (t > mCe) ? mCs : t;
    end else begin
      if (mCol >= mCe) begin mCol = mCs; t = mRow + 1; end else begin mCol++; t = mRow; end
      mRow = (t > mRe) ? mRs : t;
    end
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(posedge clk); #1;
    expQ.push_back({13'(mRow * 64 + mCol), d});
    modelStep(colMajor);
    byteValid = 1; byteIn = d;
    @(posedge clk); #1;
    byteValid = 0;
  endtask

  task automatic loadWin(input int cs, input int ce, input int rs, input int re, input bit alsoByte);
    @(posedge clk); #1;
    winLoad = 1; colFirst = 6'(cs); colLast = 6'(ce);
    rowFirst = 7'(rs); rowLast = 7'(re);
    byteValid = alsoByte; byteIn = 8'hEE;
    mCs = cs; mCe = ce; mRs = rs % 80; mRe = re % 80; mCol = mCs; mRow = mRs;
    @(posedge clk); #1;
    winLoad = 0; byteValid = 0;
  endtask

  // monitor: every write cycle must match the next expected item
  always @(negedge clk) begin
    if (rst_n && memWe) begin
      if (expQ.size() == 0) check(0, "R8 unexpected write", int'(memAddr), -1);
      else begin
        logic [20:0] e;
        e = expQ.pop_front();
        check(memAddr == e[20:8], "R2 addr", int'(memAddr), int'(e[20:8]));
        check(memData == e[7:0], "R2 data", int'(memData), int'(e[7:0]));
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(memWe == 0, "R1 memWe", memWe, 0);
    check(redrawPending == 0, "R1 redraw", redrawPending, 0);
    doWrite(8'h11);                       // R1: address 0
    @(negedge clk);
    check(redrawPending == 1, "R9 set", redrawPending, 1);
    @(posedge clk); #1 redrawAck = 1;
    @(posedge clk); #1 redrawAck = 0;
    @(negedge clk);
    check(redrawPending == 0, "R9 clear", redrawPending, 0);

    // R3 R4 R5: row-major 3x2 window, walk past its wrap
    loadWin(2, 4, 1, 2, 0);
    for (int i = 0; i < 8; i++) doWrite(8'(8'h20 + i));

    // R6: column-major 2x2 window at the bottom rows
    colMajor = 1;
    loadWin(10, 11, 78, 79, 0);
    for (int i = 0; i < 6; i++) doWrite(8'(8'h40 + i));
    colMajor = 0;

    // R7: row bounds 85/86 fold to 5/6
    loadWin(0, 0, 85, 86, 0);
    for (int i = 0; i < 4; i++) doWrite(8'(8'h60 + i));

    // R8: load and byte together; no write, origin taken
    @(posedge clk); #1 redrawAck = 1;
    @(posedge clk); #1 redrawAck = 0;
    loadWin(20, 21, 3, 3, 1);
    @(negedge clk);
    check(redrawPending == 0, "R8 no redraw", redrawPending, 0);
    doWrite(8'h77);
    doWrite(8'h78);
    doWrite(8'h79);

    // R9: write with ack keeps flag set
    @(posedge clk); #1;
    expQ.push_back({13'(mRow * 64 + mCol), 8'h99});
    modelStep(0);
    byteValid = 1; byteIn = 8'h99; redrawAck = 1;
    @(posedge clk); #1 byteValid = 0; redrawAck = 0;
    @(negedge clk);
    check(redrawPending == 1, "R9 write beats ack", redrawPending, 1);

    repeat (2) @(posedge clk);
    check(expQ.size() == 0, "R2 missing writes", expQ.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule